// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Signedness Modes

This block multiplies two 16-bit operands and either writes the product into a 40-bit accumulator, adds it to the accumulator, or subtracts it from the accumulator. A 5-bit function code picks the action. The same code picks how each operand is read: as a two's-complement value or as an unsigned value. It can also pick a rounded variant, in which both operands are signed. A mode input selects integer or fractional scaling of the product. In fractional mode the product is doubled.

The accumulator is presented as three words: an 8-bit guard word (`acc_hi`), a 16-bit middle word (`acc_mid`) and a 16-bit low word (`acc_lo`). An overflow flag tells a downstream condition evaluator when the accumulated value has left the signed 32-bit range that the middle and low words hold. The work takes two register stages. Stage one (decode and multiply) registers the decoded operation and the scaled product. Stage two (accumulate) updates the accumulator and the flag. A new operation can start on every cycle.

Top module: `mac_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator becomes zero and `mac_ovf` becomes 0.
- R2: Function code 00000 leaves the accumulator and `mac_ovf` unchanged.
- R3: Any function code with bit 4 set leaves the accumulator and `mac_ovf` unchanged.
- R4: Codes 00100, 00101, 00110 and 00111 load the accumulator with the product. The operand signedness for these codes is, in order, X signed and Y signed, X signed and Y unsigned, X unsigned and Y signed, and both unsigned. This means code bit 1 clear marks X as signed, and code bit 0 clear marks Y as signed.
- R5: Codes 01000 to 01011 add the product to the accumulator. They use the same bit 1 and bit 0 signedness encoding as R4.
- R6: Codes 01100 to 01111 subtract the product from the accumulator. They use the same bit 1 and bit 0 signedness encoding as R4.
- R7: Codes 00001, 00010 and 00011 treat both operands as signed and then load, add or subtract the product, in that order. Each then adds 0x8000 to the 40-bit result and clears the low word.
- R8: With `frac_mode` = 1 the product is doubled before it is used. With `frac_mode` = 0 the product is used unscaled.
- R9: After every operation that changes the accumulator, `mac_ovf` is 1 exactly when accumulator bits 39 down to 31 are not all equal.
- R10: An operation sampled with `in_valid` high at a rising edge shows on the outputs after the second rising edge. Function code and operands presented with `in_valid` low have no effect.
- R11: Operations issued on consecutive cycles take effect in issue order, and each one uses the result of the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| func_code | input | 5 | Function code |
| frac_mode | input | 1 | 1 = fractional (product doubled), 0 = integer |
| x_op | input | 16 | X operand |
| y_op | input | 16 | Y operand |
| acc_hi | output | 8 | Accumulator bits 39..32 |
| acc_mid | output | 16 | Accumulator bits 31..16 |
| acc_lo | output | 16 | Accumulator bits 15..0 |
| mac_ovf | output | 1 | Accumulator outside the signed 32-bit range |

## Verification
The checker watches these properties on every cycle:
- The overflow flag stays consistent with the top nine accumulator bits.
- An idle cycle or a no-operation code leaves the accumulator untouched.
- A rounded result always has a zero low word.
- An unsigned-by-unsigned integer load never gives a negative value.
- Reset clears both the accumulator and the flag.

Other behaviour needs the bench's scenarios and its independent arithmetic model. This covers the exact value for each signedness ordering, the fractional doubling, carry-in from rounding at the 0x8000 boundary, the ignored upper half of the code space, and the issue order of back-to-back operations.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        K_NOP = 2'd0,
        K_MUL = 2'd1,
        K_ADD = 2'd2,
        K_SUB = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     xs;    // X read as two's complement
        logic     ys;    // Y read as two's complement
        logic     rnd;   // round and clear the low word
    } op_dec_t;

endpackage

// File: rtl/mac_decode.sv
module mac_decode
    import mac_pkg::*;
(
    input  logic [4:0] code,
    output op_dec_t    dec
);

    always_comb begin
        dec = '{kind: K_NOP, xs: 1'b0, ys: 1'b0, rnd: 1'b0};
        unique case (code[4:2])
            3'b000: begin
                // rounded group: both operands signed
                dec.xs  = 1'b1;
                dec.ys  = 1'b1;
                dec.rnd = (code[1:0] != 2'b00);
                unique case (code[1:0])
                    2'b00:   dec.kind = K_NOP;
                    2'b01:   dec.kind = K_MUL;
                    2'b10:   dec.kind = K_ADD;
                    default: dec.kind = K_SUB;
                endcase
            end
            3'b001: begin
                dec.kind = K_MUL;
                dec.xs   = ~code[1];
                dec.ys   = ~code[0];
            end
            3'b010: begin
                dec.kind = K_ADD;
                dec.xs   = ~code[1];
                dec.ys   = ~code[0];
            end
            3'b011: begin
                dec.kind = K_SUB;
                dec.xs   = ~code[1];
                dec.ys   = ~code[0];
            end
            default: begin
                // upper half of the code space belongs to other units
                dec.kind = K_NOP;
            end
        endcase
    end

endmodule

// File: rtl/mac_mult.sv
module mac_mult
    import mac_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_valid,
    input  op_dec_t                        dec,
    input  logic                           frac,
    input  logic [DATA_W-1:0]              x_in,
    input  logic [DATA_W-1:0]              y_in,
    output logic                           s1_valid,
    output op_dec_t                        s1_dec,
    output logic                           s1_frac,
    output logic [GUARD_W+2*DATA_W-1:0]    s1_prod
);

    localparam int ACC_W  = GUARD_W + 2 * DATA_W;
    localparam int OPX_W  = DATA_W + 1;
    localparam int PROD_W = 2 * OPX_W;

    logic signed [OPX_W-1:0]  x_ext;
    logic signed [OPX_W-1:0]  y_ext;
    logic signed [PROD_W-1:0] prod_raw;
    logic [ACC_W-1:0]         prod_wide;
    logic [ACC_W-1:0]         prod_scaled;

    always_comb begin
        x_ext       = {dec.xs & x_in[DATA_W-1], x_in};
        y_ext       = {dec.ys & y_in[DATA_W-1], y_in};
        prod_raw    = x_ext * y_ext;
        prod_wide   = {{(ACC_W-PROD_W){prod_raw[PROD_W-1]}}, prod_raw};
        prod_scaled = frac ? (prod_wide << 1) : prod_wide;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_dec   <= '{kind: K_NOP, xs: 1'b0, ys: 1'b0, rnd: 1'b0};
            s1_frac  <= 1'b0;
            s1_prod  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_dec  <= dec;
                s1_frac <= frac;
                s1_prod <= prod_scaled;
            end
        end
    end

endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          s1_valid,
    input  op_dec_t                       s1_dec,
    input  logic [GUARD_W+2*DATA_W-1:0]   s1_prod,
    output logic [GUARD_W+2*DATA_W-1:0]   acc_q,
    output logic                          ovf_q
);

    localparam int ACC_W   = GUARD_W + 2 * DATA_W;
    localparam int RANGE_W = GUARD_W + 1;
    localparam logic [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (DATA_W - 1);

    logic [ACC_W-1:0]   sum_raw;
    logic [ACC_W-1:0]   sum_fin;
    logic [RANGE_W-1:0] top_bits;
    logic               ovf_nxt;
    logic               do_update;

    always_comb begin
        unique case (s1_dec.kind)
            K_MUL:   sum_raw = s1_prod;
            K_ADD:   sum_raw = acc_q + s1_prod;
            K_SUB:   sum_raw = acc_q - s1_prod;
            default: sum_raw = acc_q;
        endcase
        if (s1_dec.rnd) begin
            sum_fin = sum_raw + HALF_LSB;
            sum_fin = {sum_fin[ACC_W-1:DATA_W], {DATA_W{1'b0}}};
        end else begin
            sum_fin = sum_raw;
        end
        top_bits  = sum_fin[ACC_W-1:2*DATA_W-1];
        ovf_nxt   = ~((&top_bits) | ~(|top_bits));
        do_update = s1_valid && (s1_dec.kind != K_NOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else if (do_update) begin
            acc_q <= sum_fin;
            ovf_q <= ovf_nxt;
        end
    end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [4:0]         func_code,
    input  logic               frac_mode,
    input  logic [DATA_W-1:0]  x_op,
    input  logic [DATA_W-1:0]  y_op,
    output logic [GUARD_W-1:0] acc_hi,
    output logic [DATA_W-1:0]  acc_mid,
    output logic [DATA_W-1:0]  acc_lo,
    output logic               mac_ovf
);

    localparam int ACC_W = GUARD_W + 2 * DATA_W;

    op_dec_t          dec;
    logic             s1_valid;
    op_dec_t          s1_dec;
    logic             s1_frac;
    logic [ACC_W-1:0] s1_prod;
    logic [ACC_W-1:0] acc_q;
    logic             ovf_q;

    mac_decode u_decode (
        .code (func_code),
        .dec  (dec)
    );

    mac_mult #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_mult (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .dec      (dec),
        .frac     (frac_mode),
        .x_in     (x_op),
        .y_in     (y_op),
        .s1_valid (s1_valid),
        .s1_dec   (s1_dec),
        .s1_frac  (s1_frac),
        .s1_prod  (s1_prod)
    );

    mac_accum #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .s1_valid (s1_valid),
        .s1_dec   (s1_dec),
        .s1_prod  (s1_prod),
        .acc_q    (acc_q),
        .ovf_q    (ovf_q)
    );

    always_comb begin
        acc_hi  = acc_q[ACC_W-1:2*DATA_W];
        acc_mid = acc_q[2*DATA_W-1:DATA_W];
        acc_lo  = acc_q[DATA_W-1:0];
        mac_ovf = ovf_q;
    end

endmodule

// File: rtl/mac_unit_checker.sv
module mac_unit_checker
    import mac_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 8
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          s1_valid,
    input op_dec_t                       s1_dec,
    input logic                          s1_frac,
    input logic [GUARD_W+2*DATA_W-1:0]   acc_q,
    input logic                          ovf_q
);

    localparam int ACC_W = GUARD_W + 2 * DATA_W;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (acc_q == '0) && !ovf_q);

    p_nop_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_dec.kind == K_NOP) |=> $stable(acc_q) && $stable(ovf_q));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(acc_q) && $stable(ovf_q));

    p_round_low_r7: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_dec.rnd && s1_dec.kind != K_NOP) |=> (acc_q[DATA_W-1:0] == '0));

    p_uu_load_r4: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_dec.kind == K_MUL && !s1_dec.xs && !s1_dec.ys && !s1_dec.rnd && !s1_frac)
        |=> !acc_q[ACC_W-1]);

    p_ovf_range_r9: assert property (@(posedge clk) disable iff (rst)
        ovf_q == !((&acc_q[ACC_W-1:2*DATA_W-1]) || !(|acc_q[ACC_W-1:2*DATA_W-1])));

endmodule

bind mac_unit mac_unit_checker #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .s1_valid (s1_valid),
    .s1_dec   (s1_dec),
    .s1_frac  (s1_frac),
    .acc_q    (acc_q),
    .ovf_q    (ovf_q)
);

// File: tb/mac_unit_bench.sv
`timescale 1ns/1ps
module mac_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [4:0]  func_code;
    logic        frac_mode;
    logic [15:0] x_op;
    logic [15:0] y_op;
    logic [7:0]  acc_hi;
    logic [15:0] acc_mid;
    logic [15:0] acc_lo;
    logic        mac_ovf;

    int checks = 0;
    int errors = 0;
    logic [39:0] exp_acc;
    logic        exp_ovf;

    always #2.5 clk = ~clk;

    mac_unit u_mac_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .func_code(func_code),
        .frac_mode(frac_mode), .x_op(x_op), .y_op(y_op),
        .acc_hi(acc_hi), .acc_mid(acc_mid), .acc_lo(acc_lo), .mac_ovf(mac_ovf)
    );

    // {code, frac, x, y}
    localparam int NVEC = 14;
    localparam logic [37:0] VEC [NVEC] = '{
        {5'b00100, 1'b0, 16'h0003, 16'hFFFE},
        {5'b00101, 1'b0, 16'hFFFF, 16'hFFFF},
        {5'b00110, 1'b0, 16'hFFFF, 16'h0002},
        {5'b00111, 1'b0, 16'hFFFF, 16'hFFFF},
        {5'b01000, 1'b0, 16'h0064, 16'h0064},
        {5'b01011, 1'b0, 16'h8000, 16'h0003},
        {5'b01100, 1'b0, 16'hFF00, 16'h0010},
        {5'b01111, 1'b0, 16'hFFFF, 16'h0001},
        {5'b00001, 1'b1, 16'h1234, 16'h5678},
        {5'b00010, 1'b1, 16'h7FFF, 16'h7FFF},
        {5'b00011, 1'b0, 16'h00FF, 16'h8001},
        {5'b01001, 1'b1, 16'hC000, 16'hC000},
        {5'b01110, 1'b1, 16'hC000, 16'hC000},
        {5'b00100, 1'b1, 16'h8000, 16'h8000}
    };

    function automatic string req_of(input logic [4:0] c, input logic f);
        string s;
        if (c[4] || c == 5'b0) s = "R2/R3";
        else if (c[4:2] == 3'b000) s = "R7";
        else if (c[3:2] == 2'b01) s = "R4";
        else if (c[3:2] == 2'b10) s = "R5";
        else s = "R6";
        if (f) s = {s, "+R8"};
        return {s, "+R9"};
    endfunction

    task automatic model_step(input logic [4:0] c, input logic f,
                              input logic [15:0] x, input logic [15:0] y);
        longint xv, yv, p, a, r;
        bit xs, ys, rd;
        int kind;
        if (c[4] || c == 5'b0) return;
        if (c[4:2] == 3'b000) begin
            rd = 1; xs = 1; ys = 1; kind = int'(c[1:0]);
        end else begin
            rd = 0; xs = !c[1]; ys = !c[0]; kind = int'(c[3:2]);
        end
        xv = xs ? longint'($signed(x)) : longint'(x);
        yv = ys ? longint'($signed(y)) : longint'(y);
        p = xv * yv;
        if (f) p = p * 2;
        a = longint'($signed(exp_acc));
        if (kind == 1) r = p;
        else if (kind == 2) r = a + p;
        else r = a - p;
        if (rd) begin
            r = r + 32768;
            r = r & ~longint'(65535);
        end
        exp_acc = r[39:0];
        exp_ovf = !((exp_acc[39:31] == 9'h000) || (exp_acc[39:31] == 9'h1FF));
    endtask

    task automatic check(input string req);
        logic [39:0] got;
        got = {acc_hi, acc_mid, acc_lo};
        checks++;
        if (got !== exp_acc || mac_ovf !== exp_ovf) begin
            errors++;
            $display("FAIL %s acc=%h ovf=%b expected acc=%h ovf=%b",
                     req, got, mac_ovf, exp_acc, exp_ovf);
        end
    endtask

    task automatic issue(input logic [4:0] c, input logic f,
                         input logic [15:0] x, input logic [15:0] y);
        @(negedge clk);
        func_code = c; frac_mode = f; x_op = x; y_op = y; in_valid = 1'b1;
        model_step(c, f, x, y);
    endtask

    task automatic settle();
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; func_code = '0; frac_mode = 1'b0;
        x_op = '0; y_op = '0;
        exp_acc = '0; exp_ovf = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset state");
        rst = 1'b0;

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i][37:33], VEC[i][32], VEC[i][31:16], VEC[i][15:0]);
            settle();
            check(req_of(VEC[i][37:33], VEC[i][32]));
        end

        // R2: no-operation code holds a known non-zero value
        issue(5'b00100, 1'b0, 16'h0123, 16'h0045); settle(); check("R4 setup");
        issue(5'b00000, 1'b0, 16'h7FFF, 16'h7FFF); settle(); check("R2 nop hold");

        // R3: ALU-range codes ignored
        issue(5'b10011, 1'b1, 16'h4000, 16'h4000); settle(); check("R3 upper code hold");
        issue(5'b11111, 1'b0, 16'hFFFF, 16'h8000); settle(); check("R3 upper code hold");

        // R10: operands with strobe low have no effect
        @(negedge clk);
        func_code = 5'b01000; x_op = 16'h1000; y_op = 16'h1000; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 strobe low ignored");

        // R7: rounding carry exactly at 0x8000
        issue(5'b00001, 1'b0, 16'h0002, 16'h4000); settle(); check("R7 round up at half");
        issue(5'b00001, 1'b0, 16'h0001, 16'h7FFF); settle(); check("R7 round below half");

        // R11: back-to-back issue order
        issue(5'b00100, 1'b0, 16'h0010, 16'h0010);
        begin
            logic [39:0] first_acc;
            logic        first_ovf;
            first_acc = exp_acc; first_ovf = exp_ovf;
            @(negedge clk);
            func_code = 5'b01100; frac_mode = 1'b0; x_op = 16'h0003; y_op = 16'h0003;
            in_valid = 1'b1;
            model_step(5'b01100, 1'b0, 16'h0003, 16'h0003);
            @(negedge clk);
            in_valid = 1'b0;
            begin
                logic [39:0] second_acc;
                logic        second_ovf;
                second_acc = exp_acc; second_ovf = exp_ovf;
                exp_acc = first_acc; exp_ovf = first_ovf;
                check("R11 first of pair");
                exp_acc = second_acc; exp_ovf = second_ovf;
            end
            @(negedge clk);
            check("R11 second of pair");
        end

        // R9: overflow then recovery into range
        issue(5'b00111, 1'b0, 16'hFFFF, 16'hFFFF); settle(); check("R9 overflow set");
        issue(5'b00100, 1'b0, 16'h0002, 16'h0002); settle(); check("R9 overflow cleared");

        // R1: reset mid-run
        issue(5'b00100, 1'b0, 16'h1234, 16'h0100); settle(); check("R4 pre-reset");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        exp_acc = '0; exp_ovf = 1'b0;
        check("R1 reset mid-run");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule